// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the execute stage of a small 8-bit accumulator machine. On every clock edge it takes the accumulator, a second operand, the current status flags and a 4-bit operation code. One clock later it presents the new accumulator value, the new flag vector and a write-enable that says whether the accumulator should be written back. Where the operand comes from (a register, memory or an immediate byte) and when an operation is issued is decided outside the block.

It covers binary addition and subtraction with and without the incoming carry, bitwise AND, OR and XOR, complement, compare, setting and inverting the carry, four accumulator rotates, and the decimal correction that follows a BCD addition. Each operation has its own rule for the flags. Compare updates the flags but never the accumulator. Complement changes the accumulator but no flag. The rotates and the carry operations touch only the carry.

The flag vector has five bits: bit 0 carry (CY), bit 1 parity (P), bit 2 auxiliary carry (AC), bit 3 zero (Z), bit 4 sign (S). Operation codes are:
- ADD=0, ADC=1, SUB=2, SBB=3
- AND=4, XOR=5, OR=6, CMP=7
- RLC=8, RRC=9, RAL=10, RAR=11
- DAA=12, CMA=13, STC=14, CMC=15

Top module: `acc_alu`

## Requirements
- R1: Outputs are registered with a latency of one clock. ADD (0) gives A+B and ADC (1) gives A+B+CY, both modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R2: SUB (2) gives A−B and SBB (3) gives A−B−CY, both modulo 256. CY is set on a borrow out of bit 7 and AC on a borrow out of bit 3.
- R3: AND (4), XOR (5) and OR (6) write the bitwise result and clear CY. AND sets AC, while XOR and OR clear it.
- R4: CMA (13) writes the bitwise inverse of A and returns all five flags unchanged.
- R5: CMP (7) drives the write-enable low, returns A on the accumulator output and sets the flags as for A−B without borrow. So A<B gives CY=1, Z=0; A>B gives CY=0, Z=0; A=B gives CY=0, Z=1.
- R6: STC (14) sets CY and CMC (15) inverts CY. Neither writes the accumulator, and neither changes the other four flags.
- R7: RLC (8) and RRC (9) rotate A one place left or right in a circle and copy the bit shifted out into CY. RAL (10) and RAR (11) shift the old CY into the vacated end and put the bit shifted out into CY. All rotates leave P, AC, Z and S unchanged.
- R8: DAA (12) works in two steps. First it adds 06h if the low nibble is above 9 or AC=1, and AC becomes the carry out of bit 3 of that step. It then adds 60h if the high part of that result (including any carry out of bit 7) is above 9 or CY=1. CY is set exactly when the second correction applies.
- R9: For ADD, ADC, SUB, SBB, AND, XOR, OR, CMP and DAA, Z is 1 when the result is 00h, S is bit 7 of the result, and P is 1 when the result has an even number of ones.
- R10: The write-enable is high for every operation except CMP, STC and CMC. For those three the accumulator output equals the input A.
- R11: A synchronous active-high reset clears the accumulator output, the flag output and the write-enable to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 5 | Current flags {S,Z,AC,P,CY} |
| acc_o | output | 8 | New accumulator value |
| flags_o | output | 5 | New flags {S,Z,AC,P,CY} |
| acc_we_o | output | 1 | Accumulator write-enable |

## Verification
Several rules are checked on every cycle by the assertions:
- compare and the carry operations never assert the write-enable;
- complement returns the incoming flags untouched;
- the logical operations always clear carry;
- the rotates keep the four non-carry flags;
- zero and sign always agree with the written result of the flag-setting operations.

The arithmetic values themselves can only be shown by the bench's comparisons against its own model. These include carry and borrow out of bits 3 and 7, the two-step decimal correction, and the bit that each rotate moves into and out of carry. The bench drives a seeded random mix of all sixteen operations and directed cases for the compare table and the decimal example.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W = 5;
  localparam int FLG_CY = 0;
  localparam int FLG_P  = 1;
  localparam int FLG_AC = 2;
  localparam int FLG_Z  = 3;
  localparam int FLG_S  = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8,
    OP_RRC = 4'd9,
    OP_RAL = 4'd10,
    OP_RAR = 4'd11,
    OP_DAA = 4'd12,
    OP_CMA = 4'd13,
    OP_STC = 4'd14,
    OP_CMC = 4'd15
  } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
// Shared adder for add, add-with-carry, subtract, subtract-with-borrow and
// compare. Subtraction is formed as A + ~B + ~borrow; the carry outs are then
// inverted so that they mean "borrow".
module acc_alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full_sum;
  logic [HALF:0]     half_sum;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign c_eff    = sub_i ? ~cin_i : cin_i;
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
  assign half_sum = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
                  + {{HALF{1'b0}}, c_eff};

  assign res_o = full_sum[DATA_W-1:0];
  assign cy_o  = full_sum[DATA_W] ^ sub_i;
  assign ac_o  = half_sum[HALF] ^ sub_i;

endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise operations and complement, with the auxiliary-carry value each one
// produces.
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ac_o
);

  always_comb begin
    res_o = a_i;
    ac_o  = 1'b0;
    case (op_i)
      OP_AND: begin
        res_o = a_i & b_i;
        ac_o  = 1'b1;
      end
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_CMA:  res_o = ~a_i;
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/acc_alu_rot.sv
// Single-place accumulator rotates: circular or through the carry flag.
module acc_alu_rot
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);

  logic msb;
  logic lsb;

  assign msb = a_i[DATA_W-1];
  assign lsb = a_i[0];

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_RLC: begin
        res_o = {a_i[DATA_W-2:0], msb};
        cy_o  = msb;
      end
      OP_RRC: begin
        res_o = {lsb, a_i[DATA_W-1:1]};
        cy_o  = lsb;
      end
      OP_RAL: begin
        res_o = {a_i[DATA_W-2:0], cy_i};
        cy_o  = msb;
      end
      OP_RAR: begin
        res_o = {cy_i, a_i[DATA_W-1:1]};
        cy_o  = lsb;
      end
      default: begin
        res_o = a_i;
        cy_o  = cy_i;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_daa.sv
// Two-step decimal correction applied after a packed-BCD addition.
module acc_alu_daa #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o
);

  localparam int            HALF  = DATA_W / 2;
  localparam logic [HALF:0] NINE  = (HALF+1)'(9);
  localparam logic [DATA_W:0] FIX_LO = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] FIX_HI = (DATA_W+1)'(6) << HALF;

  logic [HALF:0]   lo_digit;
  logic            lo_fix;
  logic [HALF:0]   lo_sum;
  logic [DATA_W:0] step1;
  logic [HALF:0]   hi_digit;
  logic            hi_fix;
  logic [DATA_W:0] step2;

  assign lo_digit = {1'b0, a_i[HALF-1:0]};
  assign lo_fix   = (lo_digit > NINE) || ac_i;
  assign lo_sum   = lo_digit + (lo_fix ? (HALF+1)'(6) : '0);
  assign step1    = {1'b0, a_i} + (lo_fix ? FIX_LO : '0);
  assign hi_digit = step1[DATA_W:HALF];
  assign hi_fix   = (hi_digit > NINE) || cy_i;
  assign step2    = step1 + (hi_fix ? FIX_HI : '0);

  assign res_o = step2[DATA_W-1:0];
  assign cy_o  = hi_fix;
  assign ac_o  = lo_sum[HALF];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              acc_we_o
);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // shared adder
  logic              as_sub;
  logic              as_cin;
  logic [DATA_W-1:0] as_res;
  logic              as_cy;
  logic              as_ac;

  assign as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBB)) ? flags_i[FLG_CY] : 1'b0;

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .res_o (as_res),
    .cy_o  (as_cy),
    .ac_o  (as_ac)
  );

  logic [DATA_W-1:0] lg_res;
  logic              lg_ac;

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .res_o (lg_res),
    .ac_o  (lg_ac)
  );

  logic [DATA_W-1:0] rt_res;
  logic              rt_cy;

  acc_alu_rot #(.DATA_W(DATA_W)) u_rot (
    .op_i  (op),
    .a_i   (acc_i),
    .cy_i  (flags_i[FLG_CY]),
    .res_o (rt_res),
    .cy_o  (rt_cy)
  );

  logic [DATA_W-1:0] da_res;
  logic              da_cy;
  logic              da_ac;

  acc_alu_daa #(.DATA_W(DATA_W)) u_daa (
    .a_i   (acc_i),
    .cy_i  (flags_i[FLG_CY]),
    .ac_i  (flags_i[FLG_AC]),
    .res_o (da_res),
    .cy_o  (da_cy),
    .ac_o  (da_ac)
  );

  // result and flag selection
  logic [DATA_W-1:0] res_n;
  logic [FLAG_W-1:0] fl_n;
  logic              we_n;
  logic [DATA_W-1:0] szp_src;
  logic              szp_upd;

  always_comb begin
    res_n   = acc_i;
    fl_n    = flags_i;
    we_n    = 1'b1;
    szp_src = acc_i;
    szp_upd = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_n        = as_res;
        fl_n[FLG_CY] = as_cy;
        fl_n[FLG_AC] = as_ac;
        szp_src      = as_res;
        szp_upd      = 1'b1;
      end
      OP_CMP: begin
        we_n         = 1'b0;
        fl_n[FLG_CY] = as_cy;
        fl_n[FLG_AC] = as_ac;
        szp_src      = as_res;
        szp_upd      = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_n        = lg_res;
        fl_n[FLG_CY] = 1'b0;
        fl_n[FLG_AC] = lg_ac;
        szp_src      = lg_res;
        szp_upd      = 1'b1;
      end
      OP_CMA: res_n = lg_res;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res_n        = rt_res;
        fl_n[FLG_CY] = rt_cy;
      end
      OP_DAA: begin
        res_n        = da_res;
        fl_n[FLG_CY] = da_cy;
        fl_n[FLG_AC] = da_ac;
        szp_src      = da_res;
        szp_upd      = 1'b1;
      end
      OP_STC: begin
        we_n         = 1'b0;
        fl_n[FLG_CY] = 1'b1;
      end
      OP_CMC: begin
        we_n         = 1'b0;
        fl_n[FLG_CY] = ~flags_i[FLG_CY];
      end
      default: we_n = 1'b0;
    endcase
    if (szp_upd) begin
      fl_n[FLG_Z] = (szp_src == '0);
      fl_n[FLG_S] = szp_src[DATA_W-1];
      fl_n[FLG_P] = ~(^szp_src);
    end
  end

  // output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o    <= '0;
      flags_o  <= '0;
      acc_we_o <= 1'b0;
    end else begin
      acc_o    <= res_n;
      flags_o  <= fl_n;
      acc_we_o <= we_n;
    end
  end

  // assertions
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_CMP) |-> (!acc_we_o && acc_o == $past(acc_i))) // R5
    else $error("compare wrote the accumulator");

  AST_CARRY_OPS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_STC || $past(op_i) == OP_CMC)) |-> !acc_we_o) // R10
    else $error("carry operation wrote the accumulator");

  AST_CMA_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_CMA) |-> (flags_o == $past(flags_i))) // R4
    else $error("complement changed a flag");

  AST_LOGIC_CY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_AND || $past(op_i) == OP_XOR || $past(op_i) == OP_OR))
      |-> !flags_o[FLG_CY]) // R3
    else $error("logical operation left carry set");

  AST_STC_SETS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_STC) |-> flags_o[FLG_CY]) // R6
    else $error("set-carry did not set carry");

  AST_ROT_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= OP_RLC && $past(op_i) <= OP_RAR)
      |-> (flags_o[FLAG_W-1:1] == $past(flags_i[FLAG_W-1:1]))) // R7
    else $error("rotate changed a non-carry flag");

  AST_ZS_MATCH_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) <= OP_OR || $past(op_i) == OP_DAA))
      |-> (flags_o[FLG_Z] == (acc_o == '0) && flags_o[FLG_S] == acc_o[DATA_W-1])) // R9
    else $error("zero or sign disagrees with written result");

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

  localparam int CLK_P   = 10;
  localparam int N_RAND  = 4000;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op_i;
  logic [7:0] acc_i;
  logic [7:0] opnd_i;
  logic [4:0] flags_i;
  logic [7:0] acc_o;
  logic [4:0] flags_o;
  logic       acc_we_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_alu u_dut (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .flags_i  (flags_i),
    .acc_o    (acc_o),
    .flags_o  (flags_o),
    .acc_we_o (acc_we_o)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:                req_of = "R1";
      4'd2, 4'd3:                req_of = "R2";
      4'd4, 4'd5, 4'd6:          req_of = "R3";
      4'd7:                      req_of = "R5";
      4'd8, 4'd9, 4'd10, 4'd11:  req_of = "R7";
      4'd12:                     req_of = "R8";
      4'd13:                     req_of = "R4";
      default:                   req_of = "R6";
    endcase
  endfunction

  // flags {S,Z,AC,P,CY}; returns {we, flags, acc}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [4:0] f);
    int         cy, ac, s, d, lo, t, hi, u;
    logic [7:0] res;
    logic [4:0] nf;
    logic       we;
    logic       szp;
    cy  = int'(f[0]);
    ac  = int'(f[2]);
    nf  = f;
    res = a;
    we  = 1'b1;
    szp = 1'b0;
    case (op)
      4'd0, 4'd1: begin // R1
        s     = int'(a) + int'(b) + ((op == 4'd1) ? cy : 0);
        res   = s[7:0];
        nf[0] = (s > 255);
        nf[2] = ((int'(a) % 16) + (int'(b) % 16) + ((op == 4'd1) ? cy : 0)) > 15;
        szp   = 1'b1;
      end
      4'd2, 4'd3, 4'd7: begin // R2, R5
        d     = int'(a) - int'(b) - ((op == 4'd3) ? cy : 0);
        nf[0] = (d < 0);
        nf[2] = ((int'(a) % 16) - (int'(b) % 16) - ((op == 4'd3) ? cy : 0)) < 0;
        res   = d[7:0];
        szp   = 1'b1;
      end
      4'd4: begin res = a & b; nf[0] = 0; nf[2] = 1; szp = 1'b1; end // R3
      4'd5: begin res = a ^ b; nf[0] = 0; nf[2] = 0; szp = 1'b1; end
      4'd6: begin res = a | b; nf[0] = 0; nf[2] = 0; szp = 1'b1; end
      4'd8:  begin res = {a[6:0], a[7]}; nf[0] = a[7]; end // R7
      4'd9:  begin res = {a[0], a[7:1]}; nf[0] = a[0]; end
      4'd10: begin res = {a[6:0], f[0]}; nf[0] = a[7]; end
      4'd11: begin res = {f[0], a[7:1]}; nf[0] = a[0]; end
      4'd12: begin // R8
        lo    = int'(a) % 16;
        t     = int'(a) + ((lo > 9 || ac == 1) ? 6 : 0);
        nf[2] = (lo + ((lo > 9 || ac == 1) ? 6 : 0)) > 15;
        hi    = t / 16;
        u     = t + ((hi > 9 || cy == 1) ? 96 : 0);
        nf[0] = (hi > 9 || cy == 1);
        res   = u[7:0];
        szp   = 1'b1;
      end
      4'd13: res = ~a; // R4
      4'd14: begin we = 1'b0; nf[0] = 1'b1; end // R6
      default: begin we = 1'b0; nf[0] = ~f[0]; end
    endcase
    if (szp) begin // R9
      nf[3] = (res == 8'h00);
      nf[4] = res[7];
      nf[1] = ~(^res);
    end
    if (op == 4'd7) begin // R5, R10
      we  = 1'b0;
      res = a;
    end
    model = {we, nf, res};
  endfunction

  task automatic apply_check(input logic [3:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [4:0] f);
    logic [13:0] exp;
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; flags_i = f;
    exp = model(op, a, b, f);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({acc_we_o, flags_o, acc_o} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h f=%b: got we=%b fl=%b acc=%h, expected we=%b fl=%b acc=%h",
               req_of(op), op, a, b, f, acc_we_o, flags_o, acc_o, exp[13], exp[12:8], exp[7:0]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_i = 4'd0; acc_i = 8'h5A; opnd_i = 8'hA5; flags_i = 5'b11111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R11
    if (acc_o !== 8'h00 || flags_o !== 5'b00000 || acc_we_o !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: got acc=%h fl=%b we=%b, expected acc=00 fl=00000 we=0",
               acc_o, flags_o, acc_we_o);
    end
    rst = 1'b0;

    // directed: R1 then R8 decimal example 78h + 42h -> BAh -> 20h with carry
    apply_check(4'd0, 8'h78, 8'h42, 5'b00000);
    apply_check(4'd12, 8'hBA, 8'h00, 5'b00000);
    apply_check(4'd12, 8'h99, 8'h00, 5'b00101); // R8 both corrections forced by flags
    apply_check(4'd12, 8'hFA, 8'h00, 5'b00000); // R8 carry out of step one
    apply_check(4'd1, 8'hFF, 8'h00, 5'b00001);  // R1 wrap to zero with carry in
    apply_check(4'd3, 8'h00, 8'h00, 5'b00001);  // R2 borrow only from CY
    apply_check(4'd2, 8'h10, 8'h01, 5'b00000);  // R2 borrow out of bit 3
    // R5 compare table
    apply_check(4'd7, 8'h10, 8'h20, 5'b00000);
    apply_check(4'd7, 8'h20, 8'h10, 5'b00001);
    apply_check(4'd7, 8'h33, 8'h33, 5'b00001);
    // R7 rotates including 08h right circular -> 04h
    apply_check(4'd9, 8'h08, 8'h00, 5'b11110);
    apply_check(4'd8, 8'h80, 8'h00, 5'b00000);
    apply_check(4'd10, 8'h80, 8'h00, 5'b00001);
    apply_check(4'd11, 8'h01, 8'h00, 5'b00000);
    // R3, R4, R6, R10
    apply_check(4'd4, 8'hF0, 8'h0F, 5'b00001);
    apply_check(4'd6, 8'h00, 8'h00, 5'b00101);
    apply_check(4'd13, 8'h5A, 8'h00, 5'b10101);
    apply_check(4'd14, 8'h12, 8'h00, 5'b01010);
    apply_check(4'd15, 8'h12, 8'h00, 5'b01011);

    // constrained random over all operations (R1..R10)
    for (int i = 0; i < N_RAND; i++) begin
      logic [7:0] ra;
      logic [7:0] rb;
      ra = 8'($urandom);
      rb = ($urandom % 8 == 0) ? ra : 8'($urandom);
      apply_check(4'($urandom % 16), ra, rb, 5'($urandom));
    end

    finish_run();
  end

endmodule